// File: doc/BRIEF.md
# Video Test Pattern Generator

This block produces synthetic per-pixel colour data for bring-up and link testing of a display pipeline. A timing generator supplies the data-enable, a start-of-line strobe and a start-of-frame strobe. The block tracks the pixel position within the line and the line position within the frame, and forms a 16-bit pattern value from three parts: a programmable starting value, a horizontal term and a vertical term. The horizontal term grows by a programmed increment after every group of pixels. The vertical term grows by its own increment after every group of active lines.

The horizontal and vertical axes each take their own shaping mode: plain gradient, alternate-group inversion, or grid lines. Either axis can repeat its pattern a second time from a programmed midpoint. The 8-bit sample feeds each of the red, green and blue channels, and any channel can instead be forced to a fixed level. When the pattern is disabled, the incoming video passes through with the same latency. All outputs are registered, one cycle after the inputs.

Top module: `test_pattern_gen`

## Requirements
- R1: When data-enable was low on the previous cycle, `rgb_o` is zero. `de_o` equals `de_i` delayed by one cycle.
- R2: With `pg_en` low and data-enable high, `rgb_o` equals `vid_rgb_i` from one cycle earlier.
- R3: In gradient mode on both axes, the sample for pixel k of line l is bits [15:8] of `cfg_init + cfg_hinc*floor(k/(cfg_hstep+1)) + cfg_vinc*floor(l/(cfg_vstep+1))`, taken modulo 2^16. Here k counts active pixels since the last start-of-line and l counts active lines since the last start-of-frame.
- R4: Step fields use n-1 coding. A step value of 0 applies the increment on every pixel or line. The vertical term and the line count restart at start-of-frame.
- R5: Mode code 1 is inversion. The sample is complemented when the group index (floor(k/(hstep+1)) horizontally, floor(l/(vstep+1)) vertically) is odd. When both axes invert, the two conditions combine by exclusive-or.
- R6: Mode codes 2 and 3 are grid lines. If either axis is in line mode, the sample is 0xFF on the first pixel (or line) of each group of that axis, and 0x00 otherwise. A line-mode axis overrides gradient and inversion on the other axis.
- R7: With `cfg_hrep` set, pixel index `cfg_half_w` and every pixel after it use index k-`cfg_half_w` in R3, R5 and R6.
- R8: With `cfg_vrep` set, line index `cfg_half_h` and every line after it use index l-`cfg_half_h` in R3, R5 and R6.
- R9: The channel selects map as follows: 0 gives the pattern sample, 1 gives 0x00, 2 gives 0x80, 3 gives 0xFF. `rgb_o` packs red in [23:16], green in [15:8] and blue in [7:0].
- R10: While `rst` is high and on the first cycle after it, `de_o` and `rgb_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_en | input | 1 | Select pattern (1) or incoming video (0) |
| de_i | input | 1 | Active-pixel qualifier |
| sol_i | input | 1 | Start-of-line strobe, given while de_i is low |
| sof_i | input | 1 | Start-of-frame strobe, given while de_i is low |
| vid_rgb_i | input | 24 | Incoming video pixel |
| cfg_hmode | input | 2 | Horizontal mode code |
| cfg_vmode | input | 2 | Vertical mode code |
| cfg_hrep | input | 1 | Horizontal repeat enable |
| cfg_vrep | input | 1 | Vertical repeat enable |
| cfg_half_w | input | 12 | Pixel index where the horizontal repeat restarts |
| cfg_half_h | input | 12 | Line index where the vertical repeat restarts |
| cfg_init | input | 16 | Starting pattern value |
| cfg_hinc | input | 16 | Horizontal increment |
| cfg_vinc | input | 16 | Vertical increment |
| cfg_hstep | input | 8 | Pixels per horizontal group, minus one |
| cfg_vstep | input | 8 | Lines per vertical group, minus one |
| cfg_src_r | input | 2 | Red channel source select |
| cfg_src_g | input | 2 | Green channel source select |
| cfg_src_b | input | 2 | Blue channel source select |
| de_o | output | 1 | Registered data-enable |
| rgb_o | output | 24 | Registered output pixel |

## Verification
The hardest case to reach is the mid-frame restart under a non-unit step. The restart pixel or line has to land inside a group rather than on a group boundary, and only then do an early restart and a late one produce different values. The stimulus therefore uses a step of three with a midpoint of five, so the restart falls partway through a group on both axes. It runs several lines past the vertical midpoint so that the restarted vertical term is seen advancing again. Wrap-around of the 16-bit sum is exercised with a starting value near the top of the range.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int ACC_W   = 16;
    localparam int STEP_W  = 8;
    localparam int SAMP_W  = 8;
    localparam int CHAN_N  = 3;
    localparam int PIX_W   = CHAN_N * SAMP_W;

    typedef enum logic [1:0] {
        PAT_GRAD   = 2'd0,
        PAT_INV    = 2'd1,
        PAT_LINE_A = 2'd2,
        PAT_LINE_B = 2'd3
    } pat_mode_e;

    typedef enum logic [1:0] {
        SRC_PAT  = 2'd0,
        SRC_ZERO = 2'd1,
        SRC_MID  = 2'd2,
        SRC_FULL = 2'd3
    } chan_src_e;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [STEP_W-1:0] cnt;
        logic              odd;
    } axis_view_t;

    function automatic logic is_line(input pat_mode_e m);
        return (m == PAT_LINE_A) || (m == PAT_LINE_B);
    endfunction

    function automatic logic [SAMP_W-1:0] chan_pick(input chan_src_e s,
                                                    input logic [SAMP_W-1:0] pat);
        logic [SAMP_W-1:0] r;
        case (s)
            SRC_PAT:  r = pat;
            SRC_ZERO: r = '0;
            SRC_MID:  r = {1'b1, {(SAMP_W-1){1'b0}}};
            default:  r = '1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tpg_axis.sv
module tpg_axis
    import tpg_pkg::*;
#(
    parameter int POS_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              adv,
    input  logic              rep_en,
    input  logic [POS_W-1:0]  half,
    input  logic [STEP_W-1:0] step,
    input  logic [ACC_W-1:0]  inc,
    output axis_view_t        view_o
);

    axis_view_t       state_q;
    axis_view_t       eff;
    axis_view_t       nxt;
    logic [POS_W-1:0] pos_q;
    logic             restart;

    // Repeat restarts the walk on the midpoint position itself.
    assign restart = rep_en && (pos_q == half);

    always_comb begin
        eff = restart ? '0 : state_q;
        nxt = eff;
        if (eff.cnt == step) begin
            nxt.cnt = '0;
            nxt.acc = eff.acc + inc;
            nxt.odd = ~eff.odd;
        end else begin
            nxt.cnt = eff.cnt + 1'b1;
        end
    end

    assign view_o = eff;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state_q <= '0;
            pos_q   <= '0;
        end else if (adv) begin
            state_q <= nxt;
            pos_q   <= pos_q + 1'b1;
        end
    end

    // R4
    clear_pos_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (pos_q == '0) && (state_q.acc == '0));

    // R7
    restart_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (restart && adv && !clear && (step == '0)) |=> (state_q.acc == $past(inc)));

    // R3
    adv_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !clear) |=> (pos_q == $past(pos_q) + 1'b1));

endmodule

// File: rtl/tpg_shade.sv
module tpg_shade
    import tpg_pkg::*;
(
    input  axis_view_t        hview,
    input  axis_view_t        vview,
    input  logic [ACC_W-1:0]  init,
    input  pat_mode_e         hmode,
    input  pat_mode_e         vmode,
    input  chan_src_e         src_r,
    input  chan_src_e         src_g,
    input  chan_src_e         src_b,
    output logic [PIX_W-1:0]  pix_o
);

    logic [ACC_W-1:0]  sum;
    logic [SAMP_W-1:0] base;
    logic [SAMP_W-1:0] samp;
    logic              hline;
    logic              vline;
    logic              hit;
    logic              flip;
    chan_src_e         srcs [CHAN_N];

    assign sum   = init + hview.acc + vview.acc;
    assign base  = sum[ACC_W-1 -: SAMP_W];
    assign hline = is_line(hmode);
    assign vline = is_line(vmode);
    assign hit   = (hline && (hview.cnt == '0)) || (vline && (vview.cnt == '0));
    assign flip  = ((hmode == PAT_INV) && hview.odd) ^ ((vmode == PAT_INV) && vview.odd);

    always_comb begin
        if (hline || vline) samp = hit ? '1 : '0;
        else                samp = base ^ {SAMP_W{flip}};
    end

    assign srcs[0] = src_b;
    assign srcs[1] = src_g;
    assign srcs[2] = src_r;

    for (genvar c = 0; c < CHAN_N; c++) begin : g_chan
        assign pix_o[c*SAMP_W +: SAMP_W] = chan_pick(srcs[c], samp);
    end

endmodule

// File: rtl/test_pattern_gen.sv
module test_pattern_gen
    import tpg_pkg::*;
#(
    parameter int POS_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pg_en,
    input  logic               de_i,
    input  logic               sol_i,
    input  logic               sof_i,
    input  logic [23:0]        vid_rgb_i,
    input  logic [1:0]         cfg_hmode,
    input  logic [1:0]         cfg_vmode,
    input  logic               cfg_hrep,
    input  logic               cfg_vrep,
    input  logic [POS_W-1:0]   cfg_half_w,
    input  logic [POS_W-1:0]   cfg_half_h,
    input  logic [15:0]        cfg_init,
    input  logic [15:0]        cfg_hinc,
    input  logic [15:0]        cfg_vinc,
    input  logic [7:0]         cfg_hstep,
    input  logic [7:0]         cfg_vstep,
    input  logic [1:0]         cfg_src_r,
    input  logic [1:0]         cfg_src_g,
    input  logic [1:0]         cfg_src_b,
    output logic               de_o,
    output logic [23:0]        rgb_o
);

    axis_view_t       hview;
    axis_view_t       vview;
    logic [PIX_W-1:0] pat_pix;
    logic             line_end;

    // A line ends on the first blank cycle after active pixels.
    assign line_end = de_o && !de_i;

    tpg_axis #(.POS_W(POS_W)) u_hax (
        .clk    (clk),
        .rst    (rst),
        .clear  (sol_i),
        .adv    (de_i),
        .rep_en (cfg_hrep),
        .half   (cfg_half_w),
        .step   (cfg_hstep),
        .inc    (cfg_hinc),
        .view_o (hview)
    );

    tpg_axis #(.POS_W(POS_W)) u_vax (
        .clk    (clk),
        .rst    (rst),
        .clear  (sof_i),
        .adv    (line_end),
        .rep_en (cfg_vrep),
        .half   (cfg_half_h),
        .step   (cfg_vstep),
        .inc    (cfg_vinc),
        .view_o (vview)
    );

    tpg_shade u_shade (
        .hview (hview),
        .vview (vview),
        .init  (cfg_init),
        .hmode (pat_mode_e'(cfg_hmode)),
        .vmode (pat_mode_e'(cfg_vmode)),
        .src_r (chan_src_e'(cfg_src_r)),
        .src_g (chan_src_e'(cfg_src_g)),
        .src_b (chan_src_e'(cfg_src_b)),
        .pix_o (pat_pix)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            de_o  <= 1'b0;
            rgb_o <= '0;
        end else begin
            de_o  <= de_i;
            if (!de_i)      rgb_o <= '0;
            else if (pg_en) rgb_o <= pat_pix;
            else            rgb_o <= vid_rgb_i;
        end
    end

    // R1
    blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(de_i)) |-> (rgb_o == '0));

    // R1
    de_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (de_o == $past(de_i)));

    // R2
    pass_video_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(de_i) && !$past(pg_en)) |-> (rgb_o == $past(vid_rgb_i)));

    // R9
    red_full_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(de_i && pg_en && (cfg_src_r == 2'd3))) |-> (rgb_o[23:16] == 8'hFF));

endmodule

// File: tb/tb_test_pattern_gen.sv
module tb_test_pattern_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pg_en = 1'b1;
    logic        de_i = 1'b0;
    logic        sol_i = 1'b0;
    logic        sof_i = 1'b0;
    logic [23:0] vid_rgb_i = '0;
    logic [1:0]  cfg_hmode = 2'd0;
    logic [1:0]  cfg_vmode = 2'd0;
    logic        cfg_hrep = 1'b0;
    logic        cfg_vrep = 1'b0;
    logic [11:0] cfg_half_w = '0;
    logic [11:0] cfg_half_h = '0;
    logic [15:0] cfg_init = '0;
    logic [15:0] cfg_hinc = '0;
    logic [15:0] cfg_vinc = '0;
    logic [7:0]  cfg_hstep = '0;
    logic [7:0]  cfg_vstep = '0;
    logic [1:0]  cfg_src_r = 2'd0;
    logic [1:0]  cfg_src_g = 2'd0;
    logic [1:0]  cfg_src_b = 2'd0;
    logic        de_o;
    logic [23:0] rgb_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [24:0] exp_q [$];
    string       tag_q [$];
    int k_m = 0;
    int l_m = 0;

    always #10 clk = ~clk;

    test_pattern_gen dut (
        .clk(clk), .rst(rst), .pg_en(pg_en), .de_i(de_i), .sol_i(sol_i), .sof_i(sof_i),
        .vid_rgb_i(vid_rgb_i), .cfg_hmode(cfg_hmode), .cfg_vmode(cfg_vmode),
        .cfg_hrep(cfg_hrep), .cfg_vrep(cfg_vrep), .cfg_half_w(cfg_half_w),
        .cfg_half_h(cfg_half_h), .cfg_init(cfg_init), .cfg_hinc(cfg_hinc),
        .cfg_vinc(cfg_vinc), .cfg_hstep(cfg_hstep), .cfg_vstep(cfg_vstep),
        .cfg_src_r(cfg_src_r), .cfg_src_g(cfg_src_g), .cfg_src_b(cfg_src_b),
        .de_o(de_o), .rgb_o(rgb_o)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: run did not end, actual %0d cycles expected < 100000", cycles);
            finish_run();
        end
    end

    // Monitor: pops one expected item per clock and compares.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [24:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({de_o, rgb_o} !== e) begin
                fails++;
                $display("FAIL %s: actual de=%0b rgb=%06h expected de=%0b rgb=%06h",
                         t, de_o, rgb_o, e[24], e[23:0]);
            end
        end
    end

    function automatic logic [7:0] model_samp(int k, int l);
        int ke, le, hg, hc, vg, vc;
        logic [15:0] v;
        logic hl, vl, inv;
        ke = (cfg_hrep && k >= int'(cfg_half_w)) ? k - int'(cfg_half_w) : k;
        le = (cfg_vrep && l >= int'(cfg_half_h)) ? l - int'(cfg_half_h) : l;
        hg = ke / (int'(cfg_hstep) + 1);
        hc = ke % (int'(cfg_hstep) + 1);
        vg = le / (int'(cfg_vstep) + 1);
        vc = le % (int'(cfg_vstep) + 1);
        v  = cfg_init + 16'(int'(cfg_hinc) * hg) + 16'(int'(cfg_vinc) * vg);
        hl = cfg_hmode >= 2'd2;
        vl = cfg_vmode >= 2'd2;
        if (hl || vl) return ((hl && hc == 0) || (vl && vc == 0)) ? 8'hFF : 8'h00;
        inv = ((cfg_hmode == 2'd1) && (hg % 2 == 1)) ^ ((cfg_vmode == 2'd1) && (vg % 2 == 1));
        return v[15:8] ^ {8{inv}};
    endfunction

    function automatic logic [7:0] pick(logic [1:0] s, logic [7:0] p);
        case (s)
            2'd0: return p;
            2'd1: return 8'h00;
            2'd2: return 8'h80;
            default: return 8'hFF;
        endcase
    endfunction

    // Driver: one cycle of stimulus plus its expected output.
    task automatic drive(logic de, logic sol, logic sof, string tag);
        logic [7:0]  s;
        logic [23:0] px;
        @(negedge clk);
        if (sof) l_m = 0;
        if (sol) k_m = 0;
        de_i = de; sol_i = sol; sof_i = sof;
        vid_rgb_i = {8'(k_m * 7), 8'(l_m * 13), 8'h5A};
        s  = model_samp(k_m, l_m);
        px = pg_en ? {pick(cfg_src_r, s), pick(cfg_src_g, s), pick(cfg_src_b, s)} : vid_rgb_i;
        exp_q.push_back(de ? {1'b1, px} : 25'd0);
        tag_q.push_back(de ? tag : "R1");
        if (de) k_m++;
    endtask

    task automatic run_frame(int lines, int width, string tag);
        drive(1'b0, 1'b0, 1'b1, tag);
        for (int y = 0; y < lines; y++) begin
            drive(1'b0, 1'b1, 1'b0, tag);
            drive(1'b0, 1'b0, 1'b0, tag);
            for (int x = 0; x < width; x++) drive(1'b1, 1'b0, 1'b0, tag);
            drive(1'b0, 1'b0, 1'b0, tag);
            l_m++;
            drive(1'b0, 1'b0, 1'b0, tag);
        end
    endtask

    task automatic set_cfg(logic [1:0] hm, logic [1:0] vm, logic [15:0] ini,
                           logic [15:0] hi, logic [15:0] vi, logic [7:0] hs, logic [7:0] vs);
        cfg_hmode = hm; cfg_vmode = vm; cfg_init = ini;
        cfg_hinc = hi; cfg_vinc = vi; cfg_hstep = hs; cfg_vstep = vs;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (de_o !== 1'b0 || rgb_o !== 24'h0) begin
            fails++;
            $display("FAIL R10: actual de=%0b rgb=%06h expected de=0 rgb=000000", de_o, rgb_o);
        end
        rst = 1'b0;
        @(posedge clk); #1;
        checks++;
        if (de_o !== 1'b0 || rgb_o !== 24'h0) begin
            fails++;
            $display("FAIL R10: actual de=%0b rgb=%06h expected de=0 rgb=000000", de_o, rgb_o);
        end

        // R3: gradient on both axes, step of one
        set_cfg(2'd0, 2'd0, 16'h1000, 16'h0100, 16'h0800, 8'd0, 8'd0);
        run_frame(4, 16, "R3");
        // R3: 16-bit wrap of the sum
        set_cfg(2'd0, 2'd0, 16'hFC80, 16'h0180, 16'h0040, 8'd0, 8'd0);
        run_frame(3, 12, "R3");
        // R4: grouped steps, n-1 coding
        set_cfg(2'd0, 2'd0, 16'h0000, 16'h0300, 16'h1100, 8'd2, 8'd1);
        run_frame(5, 14, "R4");
        // R5: inversion on one axis, then both
        set_cfg(2'd1, 2'd0, 16'h2000, 16'h0400, 16'h0200, 8'd1, 8'd0);
        run_frame(3, 12, "R5");
        set_cfg(2'd1, 2'd1, 16'h2000, 16'h0400, 16'h0200, 8'd1, 8'd1);
        run_frame(5, 12, "R5");
        // R6: grid lines, code 2 and code 3, and line over gradient
        set_cfg(2'd2, 2'd3, 16'h0000, 16'h0100, 16'h0100, 8'd3, 8'd2);
        run_frame(7, 14, "R6");
        set_cfg(2'd0, 2'd2, 16'h4000, 16'h0100, 16'h0100, 8'd0, 8'd1);
        run_frame(4, 8, "R6");
        // R7 and R8: restart inside a group
        set_cfg(2'd0, 2'd0, 16'h0800, 16'h0700, 16'h0500, 8'd3, 8'd3);
        cfg_hrep = 1'b1; cfg_half_w = 12'd5;
        run_frame(3, 13, "R7");
        cfg_vrep = 1'b1; cfg_half_h = 12'd5;
        run_frame(12, 9, "R8");
        set_cfg(2'd1, 2'd2, 16'h0800, 16'h0700, 16'h0500, 8'd1, 8'd1);
        run_frame(8, 10, "R8");
        cfg_hrep = 1'b0; cfg_vrep = 1'b0;
        // R9: channel forcing
        set_cfg(2'd0, 2'd0, 16'h3300, 16'h0100, 16'h0200, 8'd0, 8'd0);
        cfg_src_r = 2'd1; cfg_src_g = 2'd2; cfg_src_b = 2'd3;
        run_frame(2, 6, "R9");
        cfg_src_r = 2'd3; cfg_src_g = 2'd0; cfg_src_b = 2'd2;
        run_frame(2, 6, "R9");
        cfg_src_r = 2'd0; cfg_src_g = 2'd1; cfg_src_b = 2'd0;
        run_frame(2, 6, "R9");
        cfg_src_r = 2'd0; cfg_src_g = 2'd0; cfg_src_b = 2'd0;
        // R2: pass-through of incoming video
        pg_en = 1'b0;
        run_frame(3, 10, "R2");
        pg_en = 1'b1;
        run_frame(2, 5, "R3");

        repeat (4) drive(1'b0, 1'b0, 1'b0, "R1");
        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end

endmodule